// File: doc/BRIEF.md
# Set-Associative Address Translation Cache with Access Rights

This block caches translations from virtual to physical addresses for a paged memory system with 1 KB pages. A lookup request carries a 32-bit virtual address and an access kind (read, write or execute). In the cycle after the request is sampled, the block reports whether the page is cached, the 32-bit physical address, and whether the cached rights forbid the requested access.

Storage is split into 4 ways of 32 sets, which gives 128 entries. Each entry holds a valid flag, a 17-bit tag, a 22-bit physical page number and three rights flags. A fill port writes a new translation into the set its page number selects. The fill reuses a way that already holds the same page; failing that, it takes an empty way; failing that, it takes a way picked by a free-running pseudo-random generator. No usage history is kept. A flush input empties the whole structure in one cycle.

Walking the page tables is left to the requester. On a miss, the requester fetches the translation elsewhere and supplies it through the fill port.

Top module: `tlb_xlate`

## Requirements
- R1: Virtual address bits [9:0] are the page offset. Bits [31:10] are the 22-bit page number. Page number bits [4:0] (address bits [14:10]) select the set. Page number bits [21:5] are the tag that is stored and compared.
- R2: A request is sampled at a rising edge. During the following cycle, hit, address and fault are driven combinationally from that sampled request. When the sampled request is not valid, all three outputs are zero.
- R3: On a hit, the physical address is the entry's page number in bits [31:10] followed by the request's unchanged offset. On a miss, hit, fault and address are all zero.
- R4: Rights bit 0 permits read, bit 1 permits write and bit 2 permits execute. The access code is 0 for read, 1 for write, 2 for execute, and 3 is reserved. Fault is raised on a hit whose rights lack the requested kind, and always on a hit with code 3. The translation is still reported when fault is raised.
- R5: A lookup sampled at the same edge as a fill sees the newly written entry.
- R6: A fill whose page number is already cached overwrites that entry in place. Otherwise the fill takes the lowest-numbered empty way of the set.
- R7: A fill into a full set replaces exactly one existing entry of that set, chosen by the pseudo-random generator. Entries in other sets are unaffected.
- R8: A flush empties every entry in one cycle. A fill presented in the same cycle is dropped. A lookup sampled at the flush edge misses.
- R9: Reset empties every entry and drives hit, fault and address to zero.
- R10: At most one way matches any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lu_valid_i | input | 1 | Lookup request present |
| lu_vaddr_i | input | 32 | Virtual address to translate |
| lu_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| lu_hit_o | output | 1 | Translation found |
| lu_paddr_o | output | 32 | Physical address, zero on miss |
| lu_fault_o | output | 1 | Hit whose rights forbid the access |
| fill_en_i | input | 1 | Write a translation |
| fill_vpn_i | input | 22 | Virtual page number of the new entry |
| fill_ppn_i | input | 22 | Physical page number of the new entry |
| fill_perm_i | input | 3 | Rights: bit 0 read, bit 1 write, bit 2 execute |
| inval_all_i | input | 1 | Flush every entry |

## Verification
The hardest states to reach from the ports are the full set and the refill of a page that is already cached. The random victim cannot be predicted, so the bench first fills one set with four distinct tags. One of those fills is a refill of an existing page. Before forcing a replacement, the bench checks that all four tags hit, which shows the refill did not create a duplicate. It then fills a fifth tag and counts the surviving hits: exactly three of the old four must remain, and an entry in another set must still hit. A flush issued together with a fill then shows that the fill is dropped.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W_D   = 32;
    localparam int OFF_W_D  = 10;
    localparam int PPN_W_D  = 22;
    localparam int WAYS_D   = 4;
    localparam int SETS_D   = 32;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    // bit 0 read, bit 1 write, bit 2 execute
    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    function automatic logic perm_allows(perm_t p, acc_e a);
        case (a)
            ACC_READ:  return p.r;
            ACC_WRITE: return p.w;
            ACC_EXEC:  return p.x;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
    parameter int                W     = 8,
    parameter logic [W-1:0]      TAPS  = 8'hB8,
    parameter int                OUT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    output logic [OUT_W-1:0] rnd_o
);
    logic [W-1:0] state_q;
    logic         fb;

    assign fb    = ^(state_q & TAPS);
    assign rnd_o = state_q[OUT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) state_q <= {{(W-1){1'b0}}, 1'b1};
        else     state_q <= {state_q[W-2:0], fb};
    end
endmodule

// File: rtl/tlb_way.sv
module tlb_way
    import tlb_pkg::*;
#(
    parameter int SETS  = 32,
    parameter int TAG_W = 17,
    parameter int PPN_W = 22,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PPN_W-1:0] wr_ppn,
    input  perm_t            wr_perm,
    output logic             wr_slot_valid,
    output logic             wr_slot_match,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_match,
    output logic [PPN_W-1:0] rd_ppn,
    output perm_t            rd_perm
);
    logic [SETS-1:0]  valid_q;
    logic [TAG_W-1:0] tag_q  [SETS];
    logic [PPN_W-1:0] ppn_q  [SETS];
    perm_t            perm_q [SETS];

    always_ff @(posedge clk) begin
        if (rst || flush)  valid_q         <= '0;
        else if (wr_en)    valid_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            ppn_q[wr_idx]  <= wr_ppn;
            perm_q[wr_idx] <= wr_perm;
        end
    end

    assign wr_slot_valid = valid_q[wr_idx];
    assign wr_slot_match = valid_q[wr_idx] && (tag_q[wr_idx] == wr_tag);
    assign rd_match      = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    assign rd_ppn        = ppn_q[rd_idx];
    assign rd_perm       = perm_q[rd_idx];
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  match_vec,
    input  logic [WAYS-1:0]  valid_vec,
    input  logic [WAY_W-1:0] rnd,
    output logic [WAYS-1:0]  sel_o
);
    always_comb begin
        sel_o = '0;
        if (|match_vec) begin
            sel_o = match_vec;
        end else if (!(&valid_vec)) begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (!valid_vec[w]) sel_o = WAYS'(1) << w;
            end
        end else begin
            sel_o = WAYS'(1) << rnd;
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int VA_W  = VA_W_D,
    parameter int OFF_W = OFF_W_D,
    parameter int PPN_W = PPN_W_D,
    parameter int WAYS  = WAYS_D,
    parameter int SETS  = SETS_D,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = VPN_W - IDX_W,
    localparam int PA_W  = PPN_W + OFF_W,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lu_valid_i,
    input  logic [VA_W-1:0]  lu_vaddr_i,
    input  logic [1:0]       lu_acc_i,
    output logic             lu_hit_o,
    output logic [PA_W-1:0]  lu_paddr_o,
    output logic             lu_fault_o,
    input  logic             fill_en_i,
    input  logic [VPN_W-1:0] fill_vpn_i,
    input  logic [PPN_W-1:0] fill_ppn_i,
    input  logic [2:0]       fill_perm_i,
    input  logic             inval_all_i
);
    logic            req_v_q;
    logic [VA_W-1:0] req_va_q;
    acc_e            req_acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_v_q   <= 1'b0;
            req_va_q  <= '0;
            req_acc_q <= ACC_READ;
        end else begin
            req_v_q   <= lu_valid_i;
            req_va_q  <= lu_vaddr_i;
            req_acc_q <= acc_e'(lu_acc_i);
        end
    end

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [TAG_W-1:0] rd_tag, wr_tag;
    assign rd_idx = req_va_q[OFF_W +: IDX_W];
    assign rd_tag = req_va_q[VA_W-1 -: TAG_W];
    assign wr_idx = fill_vpn_i[IDX_W-1:0];
    assign wr_tag = fill_vpn_i[VPN_W-1 -: TAG_W];

    logic [WAYS-1:0]  rd_match, slot_valid, slot_match, victim, way_wr;
    logic [PPN_W-1:0] way_ppn  [WAYS];
    perm_t            way_perm [WAYS];
    logic [WAY_W-1:0] rnd;
    logic [WAYS-1:0]  hit_vec;

    tlb_lfsr #(.W(8), .TAPS(8'hB8), .OUT_W(WAY_W)) u_lfsr (
        .clk(clk), .rst(rst), .rnd_o(rnd)
    );

    tlb_victim #(.WAYS(WAYS)) u_victim (
        .match_vec(slot_match), .valid_vec(slot_valid), .rnd(rnd), .sel_o(victim)
    );

    assign way_wr = victim & {WAYS{fill_en_i && !inval_all_i}};

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tlb_way #(.SETS(SETS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_way (
            .clk(clk), .rst(rst), .flush(inval_all_i),
            .wr_en(way_wr[w]), .wr_idx(wr_idx), .wr_tag(wr_tag),
            .wr_ppn(fill_ppn_i), .wr_perm(perm_t'(fill_perm_i)),
            .wr_slot_valid(slot_valid[w]), .wr_slot_match(slot_match[w]),
            .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_match(rd_match[w]),
            .rd_ppn(way_ppn[w]), .rd_perm(way_perm[w])
        );
    end

    assign hit_vec = rd_match & {WAYS{req_v_q}};

    logic [PPN_W-1:0] sel_ppn;
    perm_t            sel_perm;
    always_comb begin
        sel_ppn  = '0;
        sel_perm = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                sel_ppn  = sel_ppn | way_ppn[w];
                sel_perm = sel_perm | way_perm[w];
            end
        end
    end

    assign lu_hit_o   = |hit_vec;
    assign lu_paddr_o = lu_hit_o ? {sel_ppn, req_va_q[OFF_W-1:0]} : '0;
    assign lu_fault_o = lu_hit_o && !perm_allows(sel_perm, req_acc_q);
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
    parameter int WAYS  = 4,
    parameter int OFF_W = 10,
    parameter int VA_W  = 32,
    parameter int PA_W  = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             lu_valid_i,
    input logic             inval_all_i,
    input logic             lu_hit_o,
    input logic             lu_fault_o,
    input logic [PA_W-1:0]  lu_paddr_o,
    input logic [WAYS-1:0]  hit_vec,
    input logic [VA_W-1:0]  req_va_q
);
    // R4
    fault_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        lu_fault_o |-> lu_hit_o);

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        lu_hit_o |-> lu_paddr_o[OFF_W-1:0] == req_va_q[OFF_W-1:0]);

    // R8
    flush_miss_chk: assert property (@(posedge clk) disable iff (rst)
        inval_all_i |=> !lu_hit_o);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lu_valid_i |=> (!lu_hit_o && !lu_fault_o));

    // R10
    single_way_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));
endmodule

bind tlb_xlate tlb_xlate_chk #(
    .WAYS(WAYS), .OFF_W(OFF_W), .VA_W(VA_W), .PA_W(PA_W)
) i_chk (
    .clk(clk), .rst(rst), .lu_valid_i(lu_valid_i), .inval_all_i(inval_all_i),
    .lu_hit_o(lu_hit_o), .lu_fault_o(lu_fault_o), .lu_paddr_o(lu_paddr_o),
    .hit_vec(hit_vec), .req_va_q(req_va_q)
);

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lu_valid_i = 1'b0;
    logic [31:0] lu_vaddr_i = '0;
    logic [1:0]  lu_acc_i = '0;
    logic        lu_hit_o, lu_fault_o;
    logic [31:0] lu_paddr_o;
    logic        fill_en_i = 1'b0;
    logic [21:0] fill_vpn_i = '0, fill_ppn_i = '0;
    logic [2:0]  fill_perm_i = '0;
    logic        inval_all_i = 1'b0;

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    tlb_xlate i_tlb_xlate (.*);

    typedef struct packed {
        logic [21:0] vpn;
        logic [9:0]  off;
        logic [1:0]  acc;
        logic        hit;
        logic [21:0] ppn;
        logic        fault;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{22'h000A3, 10'h3FF, 2'd0, 1'b1, 22'h12345, 1'b0},
        '{22'h000A3, 10'h000, 2'd1, 1'b1, 22'h12345, 1'b1},
        '{22'h000A3, 10'h001, 2'd2, 1'b1, 22'h12345, 1'b1},
        '{22'h3FFFF, 10'h155, 2'd2, 1'b1, 22'h3ABCD, 1'b0},
        '{22'h3FFFF, 10'h2AA, 2'd1, 1'b1, 22'h3ABCD, 1'b0},
        '{22'h00043, 10'h010, 2'd0, 1'b1, 22'h00001, 1'b1},
        '{22'h00043, 10'h020, 2'd1, 1'b1, 22'h00001, 1'b0},
        '{22'h00023, 10'h030, 2'd0, 1'b0, 22'h00000, 1'b0},
        '{22'h00043, 10'h040, 2'd3, 1'b1, 22'h00001, 1'b1},
        '{22'h000E3, 10'h050, 2'd0, 1'b0, 22'h00000, 1'b0}
    };

    task automatic check(string req, logic [33:0] act, logic [33:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // compare {hit, fault, paddr} after a lookup
    task automatic look(string req, logic [21:0] vpn, logic [9:0] off, logic [1:0] acc,
                        logic eh, logic [21:0] eppn, logic ef);
        @(negedge clk);
        lu_valid_i = 1'b1; lu_vaddr_i = {vpn, off}; lu_acc_i = acc;
        @(negedge clk);
        check(req, {lu_hit_o, lu_fault_o, lu_paddr_o},
              {eh, ef, (eh ? {eppn, off} : 32'h0)});
    endtask

    task automatic probe(logic [21:0] vpn, output logic h);
        @(negedge clk);
        lu_valid_i = 1'b1; lu_vaddr_i = {vpn, 10'h0}; lu_acc_i = 2'd0;
        @(negedge clk);
        h = lu_hit_o;
    endtask

    task automatic fill(logic [21:0] vpn, logic [21:0] ppn, logic [2:0] perm);
        @(negedge clk);
        fill_en_i = 1'b1; fill_vpn_i = vpn; fill_ppn_i = ppn; fill_perm_i = perm;
        @(negedge clk);
        fill_en_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic h;
        int cnt;
        repeat (3) @(negedge clk);
        // R9: outputs quiet while in reset
        lu_valid_i = 1'b1; lu_vaddr_i = {22'h000A3, 10'h0};
        @(negedge clk);
        check("R9", {lu_hit_o, lu_fault_o, lu_paddr_o}, 34'h0);
        rst = 1'b0;
        // R9: empty after reset
        look("R9", 22'h000A3, 10'h0, 2'd0, 1'b0, 22'h0, 1'b0);

        // R5: fill and lookup sampled at the same edge
        @(negedge clk);
        fill_en_i = 1'b1; fill_vpn_i = 22'h000A3; fill_ppn_i = 22'h12345; fill_perm_i = 3'b001;
        lu_valid_i = 1'b1; lu_vaddr_i = {22'h000A3, 10'h123}; lu_acc_i = 2'd0;
        @(negedge clk);
        fill_en_i = 1'b0;
        check("R5", {lu_hit_o, lu_fault_o, lu_paddr_o}, {1'b1, 1'b0, 22'h12345, 10'h123});

        fill(22'h3FFFF, 22'h3ABCD, 3'b111);
        fill(22'h00043, 22'h00001, 3'b110);

        // R1 R3 R4: vector table
        for (int i = 0; i < NV; i++)
            look("R1/R3/R4", VECS[i].vpn, VECS[i].off, VECS[i].acc,
                 VECS[i].hit, VECS[i].ppn, VECS[i].fault);

        // R2: no request means quiet outputs
        @(negedge clk);
        lu_valid_i = 1'b0; lu_vaddr_i = {22'h3FFFF, 10'h0};
        @(negedge clk);
        check("R2", {lu_hit_o, lu_fault_o, lu_paddr_o}, 34'h0);

        // R6: refill in place, then two more tags fill the set
        fill(22'h000A3, 22'h2AAAA, 3'b111);
        fill(22'h00023, 22'h00111, 3'b001);
        fill(22'h000E3, 22'h00777, 3'b001);
        look("R6", 22'h000A3, 10'h005, 2'd1, 1'b1, 22'h2AAAA, 1'b0);
        look("R6", 22'h00043, 10'h006, 2'd1, 1'b1, 22'h00001, 1'b0);
        look("R6", 22'h00023, 10'h007, 2'd0, 1'b1, 22'h00111, 1'b0);
        look("R6", 22'h000E3, 10'h008, 2'd0, 1'b1, 22'h00777, 1'b0);

        // R7: full set replacement
        fill(22'h00123, 22'h00999, 3'b001);
        cnt = 0;
        probe(22'h000A3, h); cnt += int'(h);
        probe(22'h00043, h); cnt += int'(h);
        probe(22'h00023, h); cnt += int'(h);
        probe(22'h000E3, h); cnt += int'(h);
        check("R7", 34'(cnt), 34'd3);
        look("R7", 22'h00123, 10'h009, 2'd0, 1'b1, 22'h00999, 1'b0);
        look("R7", 22'h3FFFF, 10'h00A, 2'd0, 1'b1, 22'h3ABCD, 1'b0);

        // R8: flush with simultaneous fill
        @(negedge clk);
        inval_all_i = 1'b1; fill_en_i = 1'b1;
        fill_vpn_i = 22'h00005; fill_ppn_i = 22'h00055; fill_perm_i = 3'b111;
        lu_valid_i = 1'b1; lu_vaddr_i = {22'h3FFFF, 10'h0}; lu_acc_i = 2'd0;
        @(negedge clk);
        inval_all_i = 1'b0; fill_en_i = 1'b0;
        check("R8", {lu_hit_o, lu_fault_o, lu_paddr_o}, 34'h0);
        look("R8", 22'h3FFFF, 10'h0, 2'd0, 1'b0, 22'h0, 1'b0);
        look("R8", 22'h00005, 10'h0, 2'd0, 1'b0, 22'h0, 1'b0);
        look("R8", 22'h00123, 10'h0, 2'd0, 1'b0, 22'h0, 1'b0);
        fill(22'h00005, 22'h00055, 3'b100);
        look("R8", 22'h00005, 10'h0AB, 2'd2, 1'b1, 22'h00055, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule